// File: doc/BRIEF.md
# Serial Transmitter with Status Flags and Interrupt Requests

This block sends bytes on an asynchronous serial line and builds the interrupt requests for a serial channel. A host writes a byte into a holding register through a small synchronous register port. A state machine moves the byte into a shift register and sends it as a frame of ten bits. The frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit. Each bit lasts a fixed number of pulses of an external baud tick. The block keeps two transmit flags. One marks the holding register as empty. The other marks that transmission has ended.

The receiver is not part of this block. Its full, overrun, framing and parity flags arrive as inputs. The block combines them with the two transmit flags into four interrupt request outputs, and each request has its own enable bit. When the transmit enable is off, the serial pin is driven from a port level instead. A direction bit and a data bit set that level, so software can hold the line at mark or send a break. Clearing the transmit enable stops any frame that is in progress.

The state machine has four states: `ST_IDLE`, `ST_START`, `ST_DATA` and `ST_STOP`. Its transitions are:
- `ST_IDLE` to `ST_START` when a byte is waiting (load).
- `ST_START` to `ST_DATA` after a full bit time.
- `ST_DATA` to `ST_DATA` from one data bit to the next.
- `ST_DATA` to `ST_STOP` after the eighth data bit.
- `ST_STOP` to `ST_START` when another byte is waiting (chain).
- `ST_STOP` to `ST_IDLE` when nothing is waiting (finish).
- Any state to `ST_IDLE` when the transmit enable is 0 (abort).

Top module: `sertx_irq_unit`

## Requirements
- R1: After reset, the status read (address 2) returns 8'h03, with the empty flag at bit 0 and the transmission-end flag at bit 1. The control register is 0, `txd_oe` is 0, and all four requests are 0.
- R2: `irq_txe` equals the empty flag AND the control bit 1. Because the flag resets to 1, setting control bit 1 before any data write raises the request from the next cycle.
- R3: `irq_tend` equals the transmission-end flag AND the control bit 2. Because the flag resets to 1, setting control bit 2 before any data write raises the request from the next cycle.
- R4: `irq_rxf` equals `rx_full` AND the control bit 3. `irq_err` equals (`rx_ovr` OR `rx_frm` OR `rx_par`) AND the control bit 4, in the same cycle as the inputs. If `rx_frm` is set again after it was cleared, `irq_err` asserts again. Status bits 2 to 5 read back `rx_full`, `rx_ovr`, `rx_frm` and `rx_par`.
- R5: A write to address 0 stores the byte and clears both the empty flag and the transmission-end flag, starting on the cycle after the write edge.
- R6: With the transmit enable (control bit 0) set and the state machine idle, a waiting byte is loaded one cycle after it becomes waiting. In that cycle `txd_o` goes low for the start bit and the empty flag returns to 1.
- R7: A frame is a 0 start bit, eight data bits with the LSB first, and a 1 stop bit. Each bit lasts 16 `baud_tick` pulses. Cycles without a tick do not advance the frame.
- R8: If a byte is waiting when a stop bit completes, the next start bit follows at once and the transmission-end flag stays 0.
- R9: The transmission-end flag is set when a stop bit completes and no byte is waiting.
- R10: While control bit 0 is 0, `txd_o` follows the port data bit (control bit 6) and `txd_oe` follows the port direction bit (control bit 5). Clearing control bit 0 in the middle of a frame aborts it, and the port level appears in the cycle after the write edge.
- R11: With control bit 0 set and no frame in progress, `txd_o` is 1 and `txd_oe` is 1.
- R12: A status write (address 2) that has bit 1 at 0 clears the transmission-end flag. A 0 in bit 0 of that write leaves the empty flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 data, 1 control, 2 status |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 data, 1 control, 2 status |
| rd_data | output | 8 | Combinational read data |
| rx_full | input | 1 | Receiver data-full flag |
| rx_ovr | input | 1 | Receiver overrun flag (sticky) |
| rx_frm | input | 1 | Receiver framing flag (sticky) |
| rx_par | input | 1 | Receiver parity flag (sticky) |
| txd_o | output | 1 | Serial line level |
| txd_oe | output | 1 | Serial line drive enable; 0 means released |
| irq_rxf | output | 1 | Receive-full request |
| irq_txe | output | 1 | Transmit-empty request |
| irq_tend | output | 1 | Transmission-end request |
| irq_err | output | 1 | Receive-error request |

## Verification
The results of a register write appear at different times:
- The flags and the control bits change on the write edge. Requests and port levels that depend on them are due in the cycle after the write edge.
- A byte that becomes waiting is loaded one edge later, so the start bit appears two cycles after the data write edge.
- Requests driven by the receiver flags follow those inputs in the same cycle.

The bench changes inputs 1 ns after a rising edge. Its reference model steps on each rising edge, and all outputs are compared with the model at the falling edge. Each result is therefore checked in the exact cycle it is due. Named spot checks sample the outputs in those same cycles, so that the reset state, the abort and the break level are also checked on their own.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } tx_state_t;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    // Control word: the bit positions are visible to software.
    typedef struct packed {
        logic port_dat;  // bit 6
        logic port_dir;  // bit 5
        logic ie_err;    // bit 4
        logic ie_rxf;    // bit 3
        logic ie_tend;   // bit 2
        logic ie_txe;    // bit 1
        logic tx_en;     // bit 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    input  logic              finish,
    output logic [DATA_W-1:0] hold_byte,
    output logic              tdre,
    output logic              tend,
    output ctrl_t             ctrl
);

    logic data_wr;
    logic stat_wr;
    logic ctrl_wr;

    assign data_wr = wr_en && (wr_addr == ADDR_DATA);
    assign stat_wr = wr_en && (wr_addr == ADDR_STAT);
    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_byte <= '0;
            ctrl      <= '0;
        end else begin
            if (data_wr) hold_byte <= wr_data;
            if (ctrl_wr) ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    // A data write wins over a load in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tdre <= 1'b1;
        else if (data_wr) tdre <= 1'b0;
        else if (load)    tdre <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          tend <= 1'b1;
        else if (data_wr)                    tend <= 1'b0;
        else if (stat_wr && !wr_data[1])     tend <= 1'b0;
        else if (finish)                     tend <= 1'b1;
    end

    assert_wr_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (!tdre && !tend));

    assert_tend_from_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tend) |-> $past(finish));

    assert_stat_keeps_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && tdre && !load) |=> tdre);

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              baud_tick,
    input  logic              pending,
    input  logic [DATA_W-1:0] hold_byte,
    output logic              load,
    output logic              finish,
    output logic              line_bit,
    output tx_state_t         state
);

    localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    tx_state_t         state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [IDX_W-1:0]  idx, idx_n;
    logic [DATA_W-1:0] sh, sh_n;
    logic              bit_end;

    assign bit_end = baud_tick && (cnt == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
            sh    <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            idx   <= idx_n;
            sh    <= sh_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        idx_n   = idx;
        sh_n    = sh;
        load    = 1'b0;
        finish  = 1'b0;
        if (!tx_en) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
            idx_n   = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (pending) begin
                        load    = 1'b1;
                        sh_n    = hold_byte;
                        cnt_n   = '0;
                        state_n = ST_START;
                    end
                end
                ST_START: begin
                    if (bit_end) begin
                        cnt_n   = '0;
                        idx_n   = '0;
                        state_n = ST_DATA;
                    end else if (baud_tick) begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        cnt_n = '0;
                        sh_n  = sh >> 1;
                        if (idx == IDX_LAST) state_n = ST_STOP;
                        else                 idx_n   = idx + 1'b1;
                    end else if (baud_tick) begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        cnt_n = '0;
                        if (pending) begin
                            load    = 1'b1;
                            sh_n    = hold_byte;
                            state_n = ST_START;
                        end else begin
                            finish  = 1'b1;
                            state_n = ST_IDLE;
                        end
                    end else if (baud_tick) begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE:  line_bit = 1'b1;
            ST_START: line_bit = 1'b0;
            ST_DATA:  line_bit = sh[0];
            ST_STOP:  line_bit = 1'b1;
            default:  line_bit = 1'b1;
        endcase
    end

    assert_load_prompt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && tx_en && pending) |=> (state == ST_START));

    assert_no_tick_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !baud_tick && state != ST_IDLE) |=> $stable(state));

    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (state == ST_IDLE));

    assert_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && bit_end && pending && tx_en) |=> (state == ST_START));

endmodule

// File: rtl/sertx_irq.sv
module sertx_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic tdre,
    input  logic tend,
    input  logic rx_full,
    input  logic rx_ovr,
    input  logic rx_frm,
    input  logic rx_par,
    input  logic ie_txe,
    input  logic ie_tend,
    input  logic ie_rxf,
    input  logic ie_err,
    output logic irq_txe,
    output logic irq_tend,
    output logic irq_rxf,
    output logic irq_err
);

    logic any_err;

    assign any_err  = rx_ovr | rx_frm | rx_par;
    assign irq_txe  = tdre & ie_txe;
    assign irq_tend = tend & ie_tend;
    assign irq_rxf  = rx_full & ie_rxf;
    assign irq_err  = any_err & ie_err;

    assert_refire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_frm) && ie_err) |-> irq_err);

    assert_txe_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_txe |-> (tdre && ie_txe));

    assert_tend_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tend |-> (tend && ie_tend));

endmodule

// File: rtl/sertx_irq_unit.sv
module sertx_irq_unit
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rx_full,
    input  logic              rx_ovr,
    input  logic              rx_frm,
    input  logic              rx_par,
    output logic              txd_o,
    output logic              txd_oe,
    output logic              irq_rxf,
    output logic              irq_txe,
    output logic              irq_tend,
    output logic              irq_err
);

    logic [DATA_W-1:0] hold_byte;
    logic              tdre;
    logic              tend;
    ctrl_t             ctrl;
    logic              load;
    logic              finish;
    logic              line_bit;
    tx_state_t         state;

    sertx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .load      (load),
        .finish    (finish),
        .hold_byte (hold_byte),
        .tdre      (tdre),
        .tend      (tend),
        .ctrl      (ctrl)
    );

    sertx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (ctrl.tx_en),
        .baud_tick (baud_tick),
        .pending   (!tdre),
        .hold_byte (hold_byte),
        .load      (load),
        .finish    (finish),
        .line_bit  (line_bit),
        .state     (state)
    );

    sertx_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tdre     (tdre),
        .tend     (tend),
        .rx_full  (rx_full),
        .rx_ovr   (rx_ovr),
        .rx_frm   (rx_frm),
        .rx_par   (rx_par),
        .ie_txe   (ctrl.ie_txe),
        .ie_tend  (ctrl.ie_tend),
        .ie_rxf   (ctrl.ie_rxf),
        .ie_err   (ctrl.ie_err),
        .irq_txe  (irq_txe),
        .irq_tend (irq_tend),
        .irq_rxf  (irq_rxf),
        .irq_err  (irq_err)
    );

    // Pin selection: shifter when enabled, port level otherwise.
    always_comb begin
        if (ctrl.tx_en) begin
            txd_o  = line_bit;
            txd_oe = 1'b1;
        end else begin
            txd_o  = ctrl.port_dat;
            txd_oe = ctrl.port_dir;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_DATA: rd_data = hold_byte;
            ADDR_CTRL: rd_data[CTRL_W-1:0] = ctrl;
            ADDR_STAT: rd_data[5:0] = {rx_par, rx_frm, rx_ovr, rx_full, tend, tdre};
            default:   rd_data = '0;
        endcase
    end

    assert_idle_mark_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.tx_en && state == ST_IDLE) |-> (txd_o && txd_oe));

    assert_start_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.tx_en && state == ST_START) |-> !txd_o);

    assert_port_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.tx_en && state != ST_IDLE) |-> (txd_o == ctrl.port_dat));

endmodule

// File: tb/sertx_irq_unit_bench.sv
`timescale 1ns/1ps
module sertx_irq_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd2;
    logic [7:0] rd_data;
    logic       rx_full = 1'b0, rx_ovr = 1'b0, rx_frm = 1'b0, rx_par = 1'b0;
    logic       txd_o, txd_oe;
    logic       irq_rxf, irq_txe, irq_tend, irq_err;

    int checks = 0;
    int fails  = 0;
    int tick_period = 1;
    int tick_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sertx_irq_unit u_sertx_irq_unit (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .rx_full(rx_full), .rx_ovr(rx_ovr), .rx_frm(rx_frm), .rx_par(rx_par),
        .txd_o(txd_o), .txd_oe(txd_oe),
        .irq_rxf(irq_rxf), .irq_txe(irq_txe), .irq_tend(irq_tend), .irq_err(irq_err)
    );

    // Baud tick: one pulse every tick_period cycles, changed after the edge.
    always @(posedge clk) begin
        #1;
        tick_cnt = tick_cnt + 1;
        if (tick_cnt >= tick_period) begin
            tick_cnt = 0;
            baud_tick = 1'b1;
        end else begin
            baud_tick = 1'b0;
        end
    end

    // Behavioural reference: frame position -1 means idle, 0..9 the bit in the frame.
    bit       m_tdre = 1'b1, m_tend = 1'b1;
    bit [7:0] m_hold = 8'd0;
    bit [6:0] m_ctrl = 7'd0;
    bit [9:0] m_frame = 10'h3FF;
    int       m_pos = -1;
    int       m_ticks = 0;

    always @(posedge clk) begin
        bit n_tdre, n_tend;
        if (!rst_n) begin
            m_tdre = 1'b1; m_tend = 1'b1; m_hold = 8'd0; m_ctrl = 7'd0;
            m_pos = -1; m_ticks = 0;
        end else begin
            n_tdre = m_tdre;
            n_tend = m_tend;
            if (!m_ctrl[0]) begin
                m_pos = -1;
                m_ticks = 0;
            end else if (m_pos < 0) begin
                if (!m_tdre) begin
                    m_frame = {1'b1, m_hold, 1'b0};
                    m_pos = 0; m_ticks = 0; n_tdre = 1'b1;
                end
            end else if (baud_tick) begin
                if (m_ticks == 15) begin
                    m_ticks = 0;
                    if (m_pos == 9) begin
                        if (!m_tdre) begin
                            m_frame = {1'b1, m_hold, 1'b0};
                            m_pos = 0; n_tdre = 1'b1;
                        end else begin
                            m_pos = -1; n_tend = 1'b1;
                        end
                    end else begin
                        m_pos = m_pos + 1;
                    end
                end else begin
                    m_ticks = m_ticks + 1;
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin m_hold = wr_data; n_tdre = 1'b0; n_tend = 1'b0; end
                    2'd1: m_ctrl = wr_data[6:0];
                    2'd2: if (!wr_data[1]) n_tend = 1'b0;
                    default: ;
                endcase
            end
            m_tdre = n_tdre;
            m_tend = n_tend;
        end
    end

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Full comparison with the reference at every falling edge.
    always @(negedge clk) begin
        logic e_txd, e_oe;
        logic [7:0] e_rd;
        if (!done) begin
            e_oe  = m_ctrl[0] | m_ctrl[5];
            e_txd = m_ctrl[0] ? ((m_pos < 0) ? 1'b1 : m_frame[m_pos]) : m_ctrl[6];
            case (rd_addr)
                2'd0: e_rd = m_hold;
                2'd1: e_rd = {1'b0, m_ctrl};
                2'd2: e_rd = {2'b00, rx_par, rx_frm, rx_ovr, rx_full, m_tend, m_tdre};
                default: e_rd = 8'd0;
            endcase
            chk("R7",  "txd_o",    {7'd0, txd_o},    {7'd0, e_txd});
            chk("R10", "txd_oe",   {7'd0, txd_oe},   {7'd0, e_oe});
            chk("R2",  "irq_txe",  {7'd0, irq_txe},  {7'd0, m_tdre & m_ctrl[1]});
            chk("R3",  "irq_tend", {7'd0, irq_tend}, {7'd0, m_tend & m_ctrl[2]});
            chk("R4",  "irq_rxf",  {7'd0, irq_rxf},  {7'd0, rx_full & m_ctrl[3]});
            chk("R4",  "irq_err",  {7'd0, irq_err},  {7'd0, (rx_ovr | rx_frm | rx_par) & m_ctrl[4]});
            chk("R5",  "rd_data",  rd_data, e_rd);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(2);
        // R1 reset state
        chk("R1", "status", rd_data, 8'h03);
        chk("R1", "oe", {7'd0, txd_oe}, 8'h00);
        chk("R1", "irqs", {4'd0, irq_rxf, irq_txe, irq_tend, irq_err}, 8'h00);

        // R2 R3: enables set before any data
        wr(2'd1, 8'h06);
        chk("R2", "early txe", {7'd0, irq_txe}, 8'h01);
        chk("R3", "early tend", {7'd0, irq_tend}, 8'h01);

        // R10 port levels: mark, break, released
        wr(2'd1, 8'h66);
        chk("R10", "mark", {6'd0, txd_oe, txd_o}, 8'h03);
        wr(2'd1, 8'h26);
        chk("R10", "break", {6'd0, txd_oe, txd_o}, 8'h02);
        wr(2'd1, 8'h06);
        chk("R10", "released", {7'd0, txd_oe}, 8'h00);

        // R11 idle mark with enable
        wr(2'd1, 8'h07);
        step(3);
        chk("R11", "idle mark", {6'd0, txd_oe, txd_o}, 8'h03);

        // R5 R6 first byte
        wr(2'd0, 8'hA5);
        chk("R5", "flags cleared", {6'd0, rd_data[1:0]}, 8'h00);
        step(1);
        chk("R6", "start bit", {7'd0, txd_o}, 8'h00);
        chk("R6", "empty again", {7'd0, rd_data[0]}, 8'h01);

        // R8 chained byte
        step(40);
        wr(2'd0, 8'h3C);
        step(100);
        chk("R8", "pending", {7'd0, rd_data[0]}, 8'h00);
        step(60);
        chk("R8", "tend low while chained", {7'd0, rd_data[1]}, 8'h00);
        step(200);
        chk("R9", "tend set", {7'd0, rd_data[1]}, 8'h01);

        // R12 status write
        wr(2'd2, 8'h00);
        chk("R12", "tend cleared, empty kept", {6'd0, rd_data[1:0]}, 8'h01);

        // R4 receive flags
        wr(2'd1, 8'h1F);
        rx_full = 1'b1; step(1);
        chk("R4", "rxf", {7'd0, irq_rxf}, 8'h01);
        rx_full = 1'b0; rx_frm = 1'b1; step(1);
        chk("R4", "frm", {7'd0, irq_err}, 8'h01);
        rx_frm = 1'b0; step(1);
        chk("R4", "frm cleared", {7'd0, irq_err}, 8'h00);
        rx_frm = 1'b1; step(1);
        chk("R4", "frm again", {7'd0, irq_err}, 8'h01);
        rx_frm = 1'b0; rx_ovr = 1'b1; step(1);
        rx_ovr = 1'b0; rx_par = 1'b1; step(1);
        rx_par = 1'b0; step(1);

        // R10 abort mid-frame into break, slower tick
        tick_period = 3;
        wr(2'd0, 8'h5A);
        step(200);
        wr(2'd1, 8'h3E);
        chk("R10", "abort break", {6'd0, txd_oe, txd_o}, 8'h02);
        wr(2'd1, 8'h1F);
        step(2);
        chk("R11", "mark after abort", {7'd0, txd_o}, 8'h01);

        // Data written while disabled waits for enable
        tick_period = 1;
        wr(2'd1, 8'h1E);
        wr(2'd0, 8'hC3);
        step(20);
        chk("R10", "held while disabled", {6'd0, txd_oe, rd_data[0]}, 8'h00);
        wr(2'd1, 8'h1F);
        step(1);
        chk("R6", "start after enable", {7'd0, txd_o}, 8'h00);
        step(200);
        chk("R9", "tend after last", {7'd0, rd_data[1]}, 8'h01);

        step(2);
        finish_run();
    end

endmodule